// File: doc/BRIEF.md
# 1-Wire ROM Command Layer

This block is the network layer of an addressable 1-Wire slave. It sits between a bit-level transceiver, which handles slot timing, and the layer that runs the device's function commands. After every bus reset it collects one command byte, least significant bit first. It then runs one of seven addressing operations against its 64-bit identity. When the operation selects the device, it raises a grant that hands the bus to the function layer.

The identity has three parts, from least to most significant bit: a family code parameter (3Ah by default), a 48-bit serial parameter, and a CRC-8 of those 56 bits. The CRC is not stored. It is computed bit by bit while the identity is being streamed. The layer keeps a resume flag, so a device that was selected earlier can be selected again without its address. It also keeps an overdrive flag, which tells the transceiver to use the faster slot timing.

Bits move on two valid/ready streams. On the receive stream the transceiver holds `rx_valid` and `rx_bit` until `rx_ready` takes them. `rx_ready` is high only while the layer expects a bit from the master. On the transmit stream the layer holds `tx_valid` and `tx_bit` steady until the transceiver raises `tx_ready` at a master read slot. A pulse on `line_reset` cancels any transfer still in flight on either stream.

Top module: `owr_rom_layer`

## Requirements
- R1: After `rst_n` is released, the layer waits for a line reset. `func_grant`, `overdrive`, `rx_ready` and `tx_valid` are all low, and the resume flag is clear.
- R2: After a line reset, `rx_ready` is high and the next 8 accepted bits form the command byte, first bit into bit 0.
- R3: Read ROM (33h) sends all 64 identity bits on the transmit stream. The order is family code, then serial number, then CRC, each field LSB first. `func_grant` rises after the last bit is accepted.
- R4: The top 8 identity bits are the CRC of the low 56 bits. The polynomial is x^8+x^5+x^4+1, the register starts at zero, and data goes in LSB first. Running all 64 bits through the same CRC gives zero.
- R5: Match ROM (55h) takes 64 bits. It grants only if every bit equals the identity. At the first differing bit it drops `rx_ready` and ignores the bus until the next line reset.
- R6: Search ROM (F0h) runs 64 rounds. Each round sends the identity bit, then its complement, then takes the master's direction bit. A direction that differs from the identity bit drops the device out until the next reset. If all 64 rounds match, the device is granted.
- R7: Skip ROM (CCh) grants right after the command byte.
- R8: The resume flag is set when Match, Search or Overdrive-Match selects the device. It is cleared by Skip, Overdrive-Skip and Read, and by a failed Match or Search. Resume (A5h) grants only while the flag is set; otherwise the layer goes idle.
- R9: Overdrive-Skip (3Ch) and Overdrive-Match (69h) received at standard speed raise `overdrive` in the same cycle that the 8th command bit is accepted. They then act as Skip and Match. Received in overdrive, they act as plain Skip and Match. `overdrive` falls only on a line reset that has `rst_slow` set.
- R10: Any other command code makes the layer idle. Until the next line reset, `rx_ready`, `tx_valid` and `func_grant` stay low.
- R11: `func_grant` stays high until the next line reset. A line reset also abandons a command that is partly received.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_bit` do not change. `rx_ready` and `tx_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_reset | input | 1 | One-cycle pulse: the transceiver saw a reset pulse on the line |
| rst_slow | input | 1 | Sampled with `line_reset`: the reset pulse had standard-speed length |
| rx_valid | input | 1 | A bit written by the master is ready |
| rx_bit | input | 1 | Value of the written bit |
| rx_ready | output | 1 | The layer accepts a written bit |
| tx_valid | output | 1 | The layer has a bit for the next master read slot |
| tx_bit | output | 1 | Value to send |
| tx_ready | input | 1 | The transceiver takes the offered bit |
| overdrive | output | 1 | Use overdrive slot timing |
| func_grant | output | 1 | The function layer owns the bus until the next line reset |

## Verification
The assertions assume the transceiver follows the stream rules. It holds `rx_valid` and `rx_bit` until they are accepted, it drops any pending bit when `line_reset` pulses, and it treats `rst_slow` as meaningful only alongside `line_reset`. The bench acts as that transceiver. It raises `rx_valid` only on a falling clock edge where it can see `rx_ready`, and it holds the bit across exactly one rising edge. It raises `tx_ready` only after seeing `tx_valid`. It sends line resets only between bits. In one scenario the bench holds `tx_ready` low for several cycles so the transmit hold rule is exercised.

// File: rtl/owr_pkg.sv
package owr_pkg;

  localparam int CRC_W = 8;
  // x^8 + x^5 + x^4 + 1 in reflected form, since bits enter LSB first
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

  localparam logic [7:0] CMD_READ     = 8'h33;
  localparam logic [7:0] CMD_MATCH    = 8'h55;
  localparam logic [7:0] CMD_SEARCH   = 8'hF0;
  localparam logic [7:0] CMD_SKIP     = 8'hCC;
  localparam logic [7:0] CMD_RESUME   = 8'hA5;
  localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [7:0] CMD_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    ST_IDLE,      // deaf until the next line reset
    ST_CMD,       // collecting the command byte
    ST_READ,      // streaming the identity out
    ST_MATCH,     // comparing the incoming address
    ST_SRCH_BIT,  // search: offer the true bit
    ST_SRCH_CMP,  // search: offer the complement
    ST_SRCH_DIR,  // search: take the master's direction
    ST_GRANT      // function layer owns the bus
  } owr_state_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    logic [CRC_W-1:0] n;
    fb = c[0] ^ b;
    n  = c >> 1;
    if (fb) n = n ^ CRC_POLY_REFL;
    return n;
  endfunction

endpackage

// File: rtl/owr_cmd_shift.sv
module owr_cmd_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              bit_in,
  output logic              done,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  // the newest bit lands in the MSB; the first bit ends up in bit 0
  assign byte_out = {bit_in, sr_q[BYTE_W-1:1]};
  assign done     = take && (cnt_q == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (take) begin
      sr_q  <= byte_out;
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/owr_id_seq.sv
module owr_id_seq
  import owr_pkg::*;
#(
  parameter int                    FAMILY_W = 8,
  parameter int                    SERIAL_W = 48,
  parameter logic [FAMILY_W-1:0]   FAMILY   = 8'h3A,
  parameter logic [SERIAL_W-1:0]   SERIAL   = 48'hA5C3_0F96_1E2D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic id_bit,
  output logic last
);
  localparam int DATA_W = FAMILY_W + SERIAL_W;
  localparam int ID_W   = DATA_W + CRC_W;
  localparam int IDX_W  = $clog2(ID_W);
  localparam logic [ID_W-1:0] DATA_PAD = {{CRC_W{1'b0}}, SERIAL, FAMILY};

  logic [IDX_W-1:0] idx_q;
  logic [CRC_W-1:0] crc_q;
  logic             in_crc;

  assign in_crc = (idx_q >= IDX_W'(DATA_W));
  assign id_bit = in_crc ? crc_q[0] : DATA_PAD[idx_q];
  assign last   = (idx_q == IDX_W'(ID_W - 1));

  // Every emitted bit goes through the CRC. In the CRC field that means
  // feeding crc_q[0] back, which gives 0 feedback and just shifts the
  // residue down so the next CRC bit reaches bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      crc_q <= '0;
    end else if (restart) begin
      idx_q <= '0;
      crc_q <= '0;
    end else if (advance) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
      crc_q <= crc_step(crc_q, id_bit);
    end
  end

  // R4: after a full identity pass the CRC residue must be zero
  a_r4_crc_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && last && !restart) |=> (crc_q == '0));

  // R4: the residue is zero whenever the pass is back at bit 0
  a_r4_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == '0) |-> (crc_q == '0));

endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
  import owr_pkg::*;
#(
  parameter int                  FAMILY_W    = 8,
  parameter int                  SERIAL_W    = 48,
  parameter logic [FAMILY_W-1:0] FAMILY_CODE = 8'h3A,
  parameter logic [SERIAL_W-1:0] SERIAL_NUM  = 48'hA5C3_0F96_1E2D,
  parameter int                  BYTE_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_reset,
  input  logic rst_slow,
  input  logic rx_valid,
  input  logic rx_bit,
  output logic rx_ready,
  output logic tx_valid,
  output logic tx_bit,
  input  logic tx_ready,
  output logic overdrive,
  output logic func_grant
);

  owr_state_e        state_q;
  logic              resume_q;
  logic              od_q;
  logic              rx_fire;
  logic              tx_fire;
  logic              cmd_take;
  logic              cmd_done;
  logic [BYTE_W-1:0] cmd_byte;
  logic              id_bit;
  logic              id_last;
  logic              bit_hit;
  logic              id_adv;

  assign rx_ready   = (state_q == ST_CMD) || (state_q == ST_MATCH) || (state_q == ST_SRCH_DIR);
  assign tx_valid   = (state_q == ST_READ) || (state_q == ST_SRCH_BIT) || (state_q == ST_SRCH_CMP);
  assign tx_bit     = (state_q == ST_SRCH_CMP) ? ~id_bit : id_bit;
  assign func_grant = (state_q == ST_GRANT);
  assign overdrive  = od_q;

  assign rx_fire  = rx_valid && rx_ready;
  assign tx_fire  = tx_valid && tx_ready;
  assign cmd_take = rx_fire && (state_q == ST_CMD) && !line_reset;
  assign bit_hit  = (rx_bit == id_bit);
  assign id_adv   = !line_reset &&
                    (((state_q == ST_READ) && tx_fire) ||
                     (((state_q == ST_MATCH) || (state_q == ST_SRCH_DIR)) && rx_fire && bit_hit));

  owr_cmd_shift #(.BYTE_W(BYTE_W)) cmd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (line_reset),
    .take     (cmd_take),
    .bit_in   (rx_bit),
    .done     (cmd_done),
    .byte_out (cmd_byte)
  );

  owr_id_seq #(
    .FAMILY_W (FAMILY_W),
    .SERIAL_W (SERIAL_W),
    .FAMILY   (FAMILY_CODE),
    .SERIAL   (SERIAL_NUM)
  ) id_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (line_reset),
    .advance (id_adv),
    .id_bit  (id_bit),
    .last    (id_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      resume_q <= 1'b0;
      od_q     <= 1'b0;
    end else if (line_reset) begin
      state_q <= ST_CMD;
      if (rst_slow) od_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: if (cmd_done) begin
          unique case (cmd_byte[7:0])
            CMD_READ: begin
              state_q  <= ST_READ;
              resume_q <= 1'b0;
            end
            CMD_MATCH:  state_q <= ST_MATCH;
            CMD_SEARCH: state_q <= ST_SRCH_BIT;
            CMD_SKIP: begin
              state_q  <= ST_GRANT;
              resume_q <= 1'b0;
            end
            CMD_RESUME: state_q <= resume_q ? ST_GRANT : ST_IDLE;
            CMD_OD_SKIP: begin
              state_q  <= ST_GRANT;
              resume_q <= 1'b0;
              od_q     <= 1'b1;
            end
            CMD_OD_MATCH: begin
              state_q <= ST_MATCH;
              od_q    <= 1'b1;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
        ST_READ: if (tx_fire && id_last) state_q <= ST_GRANT;
        ST_MATCH, ST_SRCH_DIR: if (rx_fire) begin
          if (!bit_hit) begin
            state_q  <= ST_IDLE;
            resume_q <= 1'b0;
          end else if (id_last) begin
            state_q  <= ST_GRANT;
            resume_q <= 1'b1;
          end else if (state_q == ST_SRCH_DIR) begin
            state_q <= ST_SRCH_BIT;
          end
        end
        ST_SRCH_BIT: if (tx_fire) state_q <= ST_SRCH_CMP;
        ST_SRCH_CMP: if (tx_fire) state_q <= ST_SRCH_DIR;
        default: ;
      endcase
    end
  end

  // R11: the grant persists until a line reset
  a_r11_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (func_grant && !line_reset) |=> func_grant);

  // R12: offered transmit bit stays put under back-pressure
  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !line_reset) |=> (tx_valid && $stable(tx_bit)));

  // R12: the layer never listens and talks at once
  a_r12_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));

  // R9: overdrive leaves only through a standard-length line reset
  a_r9_od_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overdrive) |-> $past(line_reset && rst_slow));

  // R9: overdrive is entered only on an accepted command bit
  a_r9_od_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overdrive) |-> $past(cmd_done && (state_q == ST_CMD)));

  // R10: the idle state stays silent until a line reset
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !line_reset) |=> (!rx_ready && !tx_valid && !func_grant));

endmodule

// File: tb/owr_rom_layer_tb.sv
module owr_rom_layer_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0]  FAM = 8'h3A;
  localparam logic [47:0] SER = 48'hA5C3_0F96_1E2D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_reset = 1'b0, rst_slow = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, tx_ready = 1'b0;
  logic rx_ready, tx_valid, tx_bit, overdrive, func_grant;

  int checks = 0;
  int errors = 0;
  logic [63:0] id_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  owr_rom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_reset(line_reset), .rst_slow(rst_slow),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .overdrive(overdrive), .func_grant(func_grant));

  function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb = c[0] ^ v[i];
      c = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lreset(input logic slow);
    @(negedge clk);
    rx_valid = 1'b0; tx_ready = 1'b0;
    line_reset = 1'b1; rst_slow = slow;
    @(negedge clk);
    line_reset = 1'b0; rst_slow = 1'b0;
  endtask

  task automatic send_bit(input logic b, input string tag);
    int n = 0;
    @(negedge clk);
    rx_valid = 1'b1; rx_bit = b;
    while (!rx_ready && n < 40) begin @(negedge clk); n++; end
    if (n >= 40) chk(1'b0, {tag, " rx handshake"}, 0, 1);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input string tag);
    for (int i = 0; i < 8; i++) send_bit(v[i], tag);
  endtask

  task automatic recv_bit(output logic b, input string tag);
    int n = 0;
    @(negedge clk);
    while (!tx_valid && n < 40) begin @(negedge clk); n++; end
    if (n >= 40) chk(1'b0, {tag, " tx handshake"}, 0, 1);
    b = tx_bit;
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic match_id(input string tag);
    for (int i = 0; i < 64; i++) send_bit(id_exp[i], tag);
  endtask

  task automatic t_reset_state;
    chk(!func_grant && !overdrive && !rx_ready && !tx_valid, "R1 reset state",
        {func_grant, overdrive, rx_ready, tx_valid}, 0);
    lreset(1'b1);
    chk(rx_ready == 1'b1, "R2 ready for command", rx_ready, 1);
    lreset(1'b1);
    send_byte(8'hA5, "R1");
    chk(!func_grant && !rx_ready, "R1 resume refused after power-up", func_grant, 0);
  endtask

  task automatic t_read_rom;
    logic [63:0] got;
    logic b;
    lreset(1'b1);
    send_byte(8'h33, "R3");
    repeat (5) @(negedge clk);
    chk(tx_valid && tx_bit == id_exp[0], "R12 tx held under back-pressure", {tx_valid, tx_bit}, {1'b1, id_exp[0]});
    for (int i = 0; i < 64; i++) begin
      recv_bit(b, "R3");
      got[i] = b;
    end
    chk(got[7:0] == FAM, "R3 family field", got[7:0], FAM);
    chk(got == id_exp, "R3 full identity", got, id_exp);
    chk(ref_crc(got, 64) == 8'h00, "R4 crc residue", ref_crc(got, 64), 0);
    chk(func_grant, "R3 grant after read", func_grant, 1);
  endtask

  task automatic t_match;
    lreset(1'b1);
    send_byte(8'h55, "R5");
    match_id("R5");
    chk(func_grant, "R5 grant on full match", func_grant, 1);
    lreset(1'b1);
    send_byte(8'h55, "R5");
    for (int i = 0; i < 20; i++) send_bit(id_exp[i], "R5");
    send_bit(~id_exp[20], "R5");
    chk(!rx_ready && !func_grant, "R5 mismatch drops out", {rx_ready, func_grant}, 0);
    repeat (10) @(negedge clk);
    chk(!rx_ready && !tx_valid && !func_grant, "R5 stays deaf", {rx_ready, tx_valid, func_grant}, 0);
  endtask

  task automatic t_search;
    logic b, c;
    int bad = 0;
    lreset(1'b1);
    send_byte(8'hF0, "R6");
    for (int i = 0; i < 64; i++) begin
      recv_bit(b, "R6");
      recv_bit(c, "R6");
      if (b != id_exp[i] || c != ~id_exp[i]) bad++;
      send_bit(id_exp[i], "R6");
    end
    chk(bad == 0, "R6 bit and complement pairs", bad, 0);
    chk(func_grant, "R6 grant after search", func_grant, 1);
    lreset(1'b1);
    send_byte(8'hF0, "R6");
    for (int i = 0; i < 6; i++) begin
      recv_bit(b, "R6"); recv_bit(c, "R6"); send_bit(id_exp[i], "R6");
    end
    recv_bit(b, "R6"); recv_bit(c, "R6");
    send_bit(~id_exp[6], "R6");
    chk(!tx_valid && !rx_ready && !func_grant, "R6 dropout on other branch",
        {tx_valid, rx_ready, func_grant}, 0);
  endtask

  task automatic t_skip_hold;
    lreset(1'b1);
    send_byte(8'hCC, "R7");
    chk(func_grant, "R7 skip grants", func_grant, 1);
    repeat (25) @(negedge clk);
    chk(func_grant && !rx_ready && !tx_valid, "R11 grant held", {func_grant, rx_ready, tx_valid}, 3'b100);
    lreset(1'b0);
    chk(!func_grant && rx_ready, "R11 line reset clears grant", {func_grant, rx_ready}, 2'b01);
  endtask

  task automatic t_resume;
    logic b;
    lreset(1'b1); send_byte(8'h55, "R8"); match_id("R8");
    lreset(1'b1); send_byte(8'hA5, "R8");
    chk(func_grant, "R8 resume after match", func_grant, 1);
    lreset(1'b1); send_byte(8'hCC, "R8");
    lreset(1'b1); send_byte(8'hA5, "R8");
    chk(!func_grant && !rx_ready, "R8 skip clears flag", func_grant, 0);
    lreset(1'b1); send_byte(8'hF0, "R8");
    for (int i = 0; i < 64; i++) begin
      recv_bit(b, "R8"); recv_bit(b, "R8"); send_bit(id_exp[i], "R8");
    end
    lreset(1'b1); send_byte(8'hA5, "R8");
    chk(func_grant, "R8 resume after search", func_grant, 1);
    lreset(1'b1); send_byte(8'h33, "R8");
    for (int i = 0; i < 64; i++) recv_bit(b, "R8");
    lreset(1'b1); send_byte(8'hA5, "R8");
    chk(!func_grant, "R8 read clears flag", func_grant, 0);
    lreset(1'b1); send_byte(8'h55, "R8"); match_id("R8");
    lreset(1'b1); send_byte(8'h55, "R8"); send_bit(~id_exp[0], "R8");
    lreset(1'b1); send_byte(8'hA5, "R8");
    chk(!func_grant, "R8 failed match clears flag", func_grant, 0);
  endtask

  task automatic t_overdrive;
    lreset(1'b1);
    send_byte(8'h3C, "R9");
    chk(overdrive && func_grant, "R9 overdrive skip", {overdrive, func_grant}, 2'b11);
    lreset(1'b0);
    chk(overdrive, "R9 kept over short reset", overdrive, 1);
    send_byte(8'h3C, "R9");
    chk(overdrive && func_grant, "R9 overdrive skip in overdrive", {overdrive, func_grant}, 2'b11);
    lreset(1'b1);
    chk(!overdrive, "R9 cleared by slow reset", overdrive, 0);
    send_byte(8'h69, "R9");
    chk(overdrive && rx_ready && !func_grant, "R9 overdrive after match code",
        {overdrive, rx_ready, func_grant}, 3'b110);
    match_id("R9");
    chk(func_grant, "R9 overdrive match grants", func_grant, 1);
    lreset(1'b0); send_byte(8'hA5, "R9");
    chk(func_grant && overdrive, "R9 resume after overdrive match", {func_grant, overdrive}, 2'b11);
    lreset(1'b1);
  endtask

  task automatic t_unknown;
    lreset(1'b1);
    send_byte(8'h00, "R10");
    repeat (10) @(negedge clk);
    chk(!rx_ready && !tx_valid && !func_grant, "R10 unknown code idles",
        {rx_ready, tx_valid, func_grant}, 0);
    lreset(1'b1);
    send_bit(1'b1, "R11"); send_bit(1'b1, "R11"); send_bit(1'b0, "R11");
    lreset(1'b1);
    send_byte(8'hCC, "R11");
    chk(func_grant, "R11 partial command abandoned", func_grant, 1);
  endtask

  initial begin
    id_exp[55:0]  = {SER, FAM};
    id_exp[63:56] = ref_crc({8'h00, SER, FAM}, 56);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read_rom();
    t_match();
    t_search();
    t_skip_hold();
    t_resume();
    t_overdrive();
    t_unknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule